// File: doc/BRIEF.md
# Prioritised Exception Entry Controller

This block decides which of several pending exception sources a processor core takes, and produces everything the core needs to enter that exception in one cycle. The sources are a power-on/reset entry, a data abort, an asynchronous active-low fast interrupt, an active-low normal interrupt, a prefetch abort, an undefined-instruction trap and a software interrupt. The controller also reads the current 32-bit status word and the return address offered by the core. It returns the new processor mode, the vector address, the new status word, and a pair of write strobes with the data for the target mode's banked saved-status register and link register (register 14). The register file uses `entry_mode` to select the bank.

The controller is a three-state machine. BOOT is the reset state: it presents a reset entry and moves to RUN on the first clock after reset is released. In RUN, the masked requests are arbitrated on every clock. If any request wins, the machine captures the winning cause, the status word and the return address, and moves RUN to ENTER. Otherwise it stays in RUN. ENTER presents the entry for exactly one cycle, ignores all requests, and always returns to RUN. The core is expected to load `next_status` as its current status when `entry_valid` is high.

The fast interrupt passes through a synchroniser of `FIQ_STAGES` flops (default one) before it reaches the arbiter. The normal interrupt, the aborts and the two instruction traps are sampled directly.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock after it goes high, the block presents a reset entry. This entry has `entry_valid`=1, vector 0x00, mode 5'b10011 and `next_status` = 0x000000D3 (status bit 7 and bit 6 set, mode field 10011, all other bits 0). During the reset entry both save strobes are 0.
- R2: When several requests are present at the same arbitration edge, exactly one is taken. The order from highest to lowest is: data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. Undefined instruction is taken over software interrupt when both are present.
- R3: The normal interrupt is a level request, active when `irq_n` is 0. It is ignored while `cur_status` bit 7 is 1. When taken, it enters mode 5'b10010 with vector 0x18.
- R4: The fast interrupt is a level request, active when `fiq_n` is 0. It is ignored while `cur_status` bit 6 is 1, and it enters mode 5'b10001 with vector 0x1C. Because of its one-flop synchroniser, it is taken one clock later than a normal interrupt applied in the same cycle. If both fall together, the normal interrupt is therefore taken.
- R5: A data abort enters mode 5'b10111 with vector 0x10. A prefetch abort enters mode 5'b10111 with vector 0x0C. An undefined instruction enters mode 5'b11011 with vector 0x04. A software interrupt enters mode 5'b10011 with vector 0x08.
- R6: On every non-reset entry, `spsr_we` and `lr_we` are both 1 for exactly the entry cycle. `saved_status` equals `cur_status` as sampled at the arbitration edge, and `saved_pc` equals `ret_pc` as sampled at that same edge.
- R7: `next_status` equals the sampled status with these changes: bits [4:0] replaced by the new mode, bit 7 set, and bit 6 set on a fast-interrupt entry (otherwise bit 6 is kept). All other bits are copied unchanged.
- R8: A request present at a rising edge in RUN is presented as an entry during the following cycle only. Requests present at the edge that ends the entry cycle are ignored. Arbitration resumes at the next edge, using the status word then current.
- R9: With no unmasked request, `entry_valid`, `spsr_we` and `lr_we` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the reset exception source |
| fiq_n | input | 1 | Asynchronous active-low fast interrupt request |
| irq_n | input | 1 | Active-low normal interrupt request |
| dabort | input | 1 | Data abort request |
| pabort | input | 1 | Prefetch abort request |
| undef | input | 1 | Undefined instruction trap request |
| swi | input | 1 | Software interrupt request |
| cur_status | input | 32 | Current status word; bit 7 masks the normal interrupt, bit 6 masks the fast interrupt |
| ret_pc | input | ADDR_W | Return address to be saved on entry |
| entry_valid | output | 1 | An exception entry is presented this cycle |
| entry_mode | output | 5 | Target mode and register bank |
| entry_vector | output | ADDR_W | Vector address to fetch from |
| next_status | output | 32 | Status word to load on entry |
| spsr_we | output | 1 | Write strobe for the target mode's saved status |
| saved_status | output | 32 | Data for the saved status register |
| lr_we | output | 1 | Write strobe for the target mode's register 14 |
| saved_pc | output | ADDR_W | Data for register 14 |

## Verification
The assertions check on every cycle that the two save strobes move together and last a single cycle. They also check that a taken normal or fast interrupt was unmasked in the saved status, that every entry sets the interrupt-disable bits it must set, and that the fast-interrupt request seen by the arbiter follows the pin one cycle late. The bench alone can show the full priority order and the mask combinations, because it sweeps all 64 request patterns under all four mask settings. It also covers the extra cycle of fast-interrupt latency, the blind entry cycle, a held interrupt that becomes masked once the new status is loaded, and the reset entry both at start-up and in mid-run.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int PSR_W  = 32;
    localparam int MODE_W = 5;
    localparam int IBIT   = 7;
    localparam int FBIT   = 6;

    typedef enum logic [2:0] {
        C_NONE, C_RESET, C_DABT, C_FIQ, C_IRQ, C_PABT, C_UND, C_SWI
    } cause_e;

    typedef enum logic [1:0] {
        ST_BOOT, ST_RUN, ST_ENTER
    } state_e;

    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;

    localparam logic [7:0] V_RESET = 8'h00;
    localparam logic [7:0] V_UND   = 8'h04;
    localparam logic [7:0] V_SWI   = 8'h08;
    localparam logic [7:0] V_PABT  = 8'h0C;
    localparam logic [7:0] V_DABT  = 8'h10;
    localparam logic [7:0] V_IRQ   = 8'h18;
    localparam logic [7:0] V_FIQ   = 8'h1C;
endpackage

// File: rtl/exc_fiq_sync.sv
module exc_fiq_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fiq_n,
    output logic fiq_req
);
    logic [STAGES-1:0] chain_q;

    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= ~fiq_n;
        end

        // R4: request reaches the arbiter one clock after the pin
        assert_fiq_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
            fiq_req |-> $past(!fiq_n));
    end else begin : g_multi
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], ~fiq_n};
        end
    end

    assign fiq_req = chain_q[STAGES-1];
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_pkg::*;
(
    input  logic   dabt,
    input  logic   fiq_req,
    input  logic   irq_req,
    input  logic   pabt,
    input  logic   und,
    input  logic   swi,
    input  logic   i_mask,
    input  logic   f_mask,
    output cause_e win
);
    always_comb begin
        if (dabt)                   win = C_DABT;
        else if (fiq_req && !f_mask) win = C_FIQ;
        else if (irq_req && !i_mask) win = C_IRQ;
        else if (pabt)              win = C_PABT;
        else if (und)               win = C_UND;
        else if (swi)               win = C_SWI;
        else                        win = C_NONE;
    end
endmodule

// File: rtl/exc_entry_fmt.sv
module exc_entry_fmt
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  cause_e              cause,
    input  logic [PSR_W-1:0]    base,
    output logic [MODE_W-1:0]   mode,
    output logic [ADDR_W-1:0]   vector,
    output logic [PSR_W-1:0]    status
);
    logic [7:0] vec_off;
    logic       set_f;

    always_comb begin
        set_f = 1'b0;
        unique case (cause)
            C_RESET: begin mode = M_SVC; vec_off = V_RESET; set_f = 1'b1; end
            C_DABT:  begin mode = M_ABT; vec_off = V_DABT;  end
            C_FIQ:   begin mode = M_FIQ; vec_off = V_FIQ;   set_f = 1'b1; end
            C_IRQ:   begin mode = M_IRQ; vec_off = V_IRQ;   end
            C_PABT:  begin mode = M_ABT; vec_off = V_PABT;  end
            C_UND:   begin mode = M_UND; vec_off = V_UND;   end
            C_SWI:   begin mode = M_SVC; vec_off = V_SWI;   end
            default: begin mode = base[MODE_W-1:0]; vec_off = V_RESET; end
        endcase
        vector = ADDR_W'(vec_off);
        status = base;
        status[MODE_W-1:0] = mode;
        status[IBIT] = 1'b1;
        if (set_f) status[FBIT] = 1'b1;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIQ_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fiq_n,
    input  logic              irq_n,
    input  logic              dabort,
    input  logic              pabort,
    input  logic              undef,
    input  logic              swi,
    input  logic [31:0]       cur_status,
    input  logic [ADDR_W-1:0] ret_pc,
    output logic              entry_valid,
    output logic [4:0]        entry_mode,
    output logic [ADDR_W-1:0] entry_vector,
    output logic [31:0]       next_status,
    output logic              spsr_we,
    output logic [31:0]       saved_status,
    output logic              lr_we,
    output logic [ADDR_W-1:0] saved_pc
);
    state_e             state_q, state_d;
    cause_e             cause_q, win;
    cause_e             fmt_cause;
    logic [PSR_W-1:0]   status_q, fmt_base;
    logic [ADDR_W-1:0]  pc_q;
    logic               fiq_req;

    exc_fiq_sync #(.STAGES(FIQ_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .fiq_n   (fiq_n),
        .fiq_req (fiq_req)
    );

    exc_prio_arb i_arb (
        .dabt    (dabort),
        .fiq_req (fiq_req),
        .irq_req (~irq_n),
        .pabt    (pabort),
        .und     (undef),
        .swi     (swi),
        .i_mask  (cur_status[IBIT]),
        .f_mask  (cur_status[FBIT]),
        .win     (win)
    );

    exc_entry_fmt #(.ADDR_W(ADDR_W)) i_fmt (
        .cause  (fmt_cause),
        .base   (fmt_base),
        .mode   (entry_mode),
        .vector (entry_vector),
        .status (next_status)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_BOOT:  state_d = ST_RUN;
            ST_RUN:   state_d = (win != C_NONE) ? ST_ENTER : ST_RUN;
            ST_ENTER: state_d = ST_RUN;
            default:  state_d = ST_BOOT;
        endcase
    end

    // state register and capture of the winning request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_BOOT;
            cause_q  <= C_NONE;
            status_q <= '0;
            pc_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && win != C_NONE) begin
                cause_q  <= win;
                status_q <= cur_status;
                pc_q     <= ret_pc;
            end
        end
    end

    // outputs
    always_comb begin
        fmt_cause    = C_NONE;
        fmt_base     = '0;
        entry_valid  = 1'b0;
        spsr_we      = 1'b0;
        lr_we        = 1'b0;
        saved_status = '0;
        saved_pc     = '0;
        unique case (state_q)
            ST_BOOT: begin
                fmt_cause   = C_RESET;
                entry_valid = 1'b1;
            end
            ST_ENTER: begin
                fmt_cause    = cause_q;
                fmt_base     = status_q;
                entry_valid  = 1'b1;
                spsr_we      = 1'b1;
                lr_we        = 1'b1;
                saved_status = status_q;
                saved_pc     = pc_q;
            end
            default: ;
        endcase
    end

    assert_save_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spsr_we == lr_we) && (!spsr_we || entry_valid));

    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spsr_we |=> !spsr_we);

    assert_irq_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spsr_we && entry_mode == M_IRQ) |-> !saved_status[IBIT]);

    assert_fiq_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spsr_we && entry_mode == M_FIQ) |-> !saved_status[FBIT]);

    assert_idis_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> next_status[IBIT]);

    assert_fdis_fiq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && entry_mode == M_FIQ) |-> next_status[FBIT]);
endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fiq_n = 1'b1, irq_n = 1'b1;
    logic          dabort = 1'b0, pabort = 1'b0, undef = 1'b0, swi = 1'b0;
    logic [31:0]   cur_status = 32'h10;
    logic [AW-1:0] ret_pc = '0;
    logic          entry_valid, spsr_we, lr_we;
    logic [4:0]    entry_mode;
    logic [AW-1:0] entry_vector, saved_pc;
    logic [31:0]   next_status, saved_status;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.ADDR_W(AW)) i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .fiq_n(fiq_n), .irq_n(irq_n),
        .dabort(dabort), .pabort(pabort), .undef(undef), .swi(swi),
        .cur_status(cur_status), .ret_pc(ret_pc),
        .entry_valid(entry_valid), .entry_mode(entry_mode),
        .entry_vector(entry_vector), .next_status(next_status),
        .spsr_we(spsr_we), .saved_status(saved_status),
        .lr_we(lr_we), .saved_pc(saved_pc)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {valid, spsr_we, lr_we, mode}
    function automatic logic [7:0] ctl();
        return {entry_valid, spsr_we, lr_we, entry_mode};
    endfunction

    task automatic expect_entry(input bit d, f, i, p, u, s, input logic [31:0] st,
                                output bit v, output logic [4:0] m,
                                output logic [31:0] vec, output logic [31:0] ns);
        bit isf = 1'b0;
        v = 1'b1;
        if (d)                 begin m = 5'b10111; vec = 32'h10; end
        else if (f && !st[6])  begin m = 5'b10001; vec = 32'h1C; isf = 1'b1; end
        else if (i && !st[7])  begin m = 5'b10010; vec = 32'h18; end
        else if (p)            begin m = 5'b10111; vec = 32'h0C; end
        else if (u)            begin m = 5'b11011; vec = 32'h04; end
        else if (s)            begin m = 5'b10011; vec = 32'h08; end
        else                   begin v = 1'b0; m = 5'b0; vec = 32'h0; end
        ns = (st & ~32'h1F) | 32'(m) | 32'h80 | (isf ? 32'h40 : 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit v;
        logic [4:0] m;
        logic [31:0] vec, ns, st;

        // R1: reset entry while reset is held
        repeat (3) @(negedge clk);
        check("R1 reset ctl", 64'(ctl()), 64'({3'b100, 5'b10011}));
        check("R1 reset vector", 64'(entry_vector), 64'h0);
        check("R1 reset status", 64'(next_status), 64'hD3);
        rst_n = 1'b1;
        #1;
        check("R1 reset held until first edge", 64'(entry_valid), 64'h1);
        @(negedge clk);
        check("R9 idle after boot", 64'(ctl() & 8'hE0), 64'h0);

        // R4: fast interrupt one cycle slower than normal interrupt
        @(negedge clk); fiq_n = 1'b0;
        @(negedge clk);
        check("R4 fiq not yet taken", 64'(entry_valid), 64'h0);
        @(negedge clk);
        check("R4 fiq ctl", 64'(ctl()), 64'({3'b111, 5'b10001}));
        check("R4 fiq vector", 64'(entry_vector), 64'h1C);
        fiq_n = 1'b1;
        repeat (2) @(negedge clk);
        fiq_n = 1'b0; irq_n = 1'b0;
        @(negedge clk);
        check("R4 irq wins same-cycle fall", 64'(ctl()), 64'({3'b111, 5'b10010}));
        fiq_n = 1'b1; irq_n = 1'b1;
        @(negedge clk);
        check("R8 no entry after lost fiq", 64'(entry_valid), 64'h0);
        @(negedge clk);

        // R3/R8: held interrupt masked after loading new status
        irq_n = 1'b0;
        @(negedge clk);
        check("R3 irq entry", 64'(ctl()), 64'({3'b111, 5'b10010}));
        cur_status = next_status;
        @(negedge clk);
        check("R8 entry lasts one cycle", 64'(entry_valid), 64'h0);
        @(negedge clk);
        check("R3 held irq masked", 64'(entry_valid), 64'h0);
        irq_n = 1'b1; cur_status = 32'h10;

        // R8: request only during the entry cycle is ignored
        @(negedge clk); pabort = 1'b1;
        @(negedge clk);
        check("R5 pabort entry", 64'(entry_vector), 64'h0C);
        pabort = 1'b0; dabort = 1'b1;
        @(negedge clk);
        dabort = 1'b0;
        check("R8 blind entry cycle a", 64'(entry_valid), 64'h0);
        @(negedge clk);
        check("R8 blind entry cycle b", 64'(entry_valid), 64'h0);

        // R2,R3,R4,R5,R6,R7,R9: sweep all request patterns under all masks
        for (int k = 0; k < 256; k++) begin
            st = (32'(k) << 24) | 32'h10 | (k[6] ? 32'h80 : 32'h0) | (k[7] ? 32'h40 : 32'h0);
            @(negedge clk);
            cur_status = st; ret_pc = 32'h1000 + 32'(k) * 4;
            fiq_n = ~k[1];
            @(negedge clk);
            dabort = k[0]; irq_n = ~k[2]; pabort = k[3]; undef = k[4]; swi = k[5];
            @(negedge clk);
            expect_entry(k[0], k[1], k[2], k[3], k[4], k[5], st, v, m, vec, ns);
            if (v) begin
                check("R2 sweep ctl", 64'(ctl()), 64'({3'b111, m}));
                check("R5 sweep vector", 64'(entry_vector), 64'(vec));
                check("R7 sweep next status", 64'(next_status), 64'(ns));
                check("R6 sweep saved", {saved_status, saved_pc}, {st, 32'h1000 + 32'(k) * 4});
            end else begin
                check("R9 sweep no entry", 64'(ctl() & 8'hE0), 64'h0);
            end
            dabort = 1'b0; irq_n = 1'b1; pabort = 1'b0; undef = 1'b0; swi = 1'b0; fiq_n = 1'b1;
            @(negedge clk);
            check("R8 sweep single cycle", 64'(ctl() & 8'hE0), 64'h0);
        end

        // R1: reset asserted in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset ctl", 64'(ctl()), 64'({3'b100, 5'b10011}));
        check("R1 mid-run reset status", 64'(next_status), 64'hD3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after mid-run reset", 64'(entry_valid), 64'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule